// File: doc/BRIEF.md
# Transmit-Empty Interrupt Generator

This block decides when a UART transmitter reports its holding stage as empty, and when that condition raises an interrupt request. It sits beside a 16-entry transmit FIFO. It watches the FIFO occupancy count, the host's holding-register write strobe and the read strobe of the interrupt identification register. It produces the empty status bit and the empty interrupt request. The FIFO storage, the serializer and the priority encoder that combines interrupt sources sit outside it. The encoder reports this source with identification code 02h, at the same priority whether FIFOs are on or off. It tells the block through `thre_top` when this source is the one being reported.

In FIFO mode with the transmit interrupt enabled, the block can slow the empty report down. Suppose the queue drains after never holding two characters at once since the last empty report. The block then holds the status low for one character time minus the final stop bit. The serializer supplies two timing pulses for this: `char_tick` marks a character boundary and `stop_tick` marks the start of the final stop bit. The delay lasts from the first `char_tick` after draining until the next `stop_tick`. When the queue has reached two entries, the report is immediate. Toggling the FIFO enable re-raises a pending interrupt at once when the transmitter is empty. All outputs are registered. No data stream passes through the block, so it has no valid/ready handshake. Every pin is a plain level or a single-cycle strobe, and the block never back-pressures the host.

Top module: `uart_thre_irq_gen`

## Requirements
- R1: After reset, `thre` is 1 and `thre_irq` is 0.
- R2: `thre` is 0 in every cycle that follows a clock edge at which `fifo_level` was nonzero.
- R3: When `fifo_en` or `tx_ie` is 0, `thre` becomes 1 at the first edge at which `fifo_level` is sampled as 0.
- R4: With `fifo_en`=1 and `tx_ie`=1, and no occupancy of 2 or more since the last rise of `thre`, a drain to 0 keeps `thre` at 0. The wait runs until the first `char_tick` sampled after the drain edge, then until a later `stop_tick`. `thre` becomes 1 at that `stop_tick` edge. A `stop_tick` seen before the `char_tick` has no effect.
- R5: With `fifo_en`=1 and `tx_ie`=1, if the occupancy reached 2 or more since the last rise of `thre`, `thre` becomes 1 at the drain edge, with no delay.
- R6: The record of occupancy 2 or more clears when `thre` rises, so the next single-entry episode is delayed again.
- R7: With `tx_ie`=1, `thre_irq` becomes 1 at the same edge at which `thre` rises, and `thre_irq` is 1 only while `thre` is 1.
- R8: A `thr_wr` strobe clears `thre_irq` at that edge. A clear wins over a simultaneous set.
- R9: An `iir_rd` strobe clears `thre_irq` only when `thre_top` is 1. With `thre_top`=0 it has no effect.
- R10: A change of `fifo_en` while the FIFO is empty cancels any running delay. It sets `thre` to 1 and, with `tx_ie`=1, raises `thre_irq` at that edge.
- R11: `tx_ie`=0 forces `thre_irq` to 0 at the next edge. A rise of `tx_ie` while empty raises `thre_irq` at that edge.
- R12: A new entry arriving during a running delay cancels it and keeps `thre` at 0. The next drain starts a fresh delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_level | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| thr_wr | input | 1 | Host write to the holding register (one-cycle strobe) |
| iir_rd | input | 1 | Host read of the interrupt identification register (strobe) |
| thre_top | input | 1 | This source is the one currently reported by the identification register |
| char_tick | input | 1 | Character-boundary pulse from the serializer |
| stop_tick | input | 1 | Start-of-final-stop-bit pulse from the serializer |
| fifo_en | input | 1 | FIFO mode enable |
| tx_ie | input | 1 | Transmit-empty interrupt enable |
| thre | output | 1 | Holding stage empty status |
| thre_irq | output | 1 | Transmit-empty interrupt request |

## Verification
The bench sweeps the peak occupancy, the enable combinations and the spacing of the two serializer ticks. For each case it computes the edge at which `thre` must rise. This catches a design that delays even after a two-entry episode, a design that never delays, and a design that counts a `stop_tick` arriving before the `char_tick`. It also runs two episodes back to back, which exposes a sticky flag that is never cleared. Further cases refill the FIFO in the middle of a delay and toggle the FIFO enable in the middle of a delay. A design that ignores `thre_top` loses interrupts on foreign identification reads, and the bench reports it. So does a design that re-raises the interrupt late after an enable change.

// File: rtl/uart_thre_pkg.sv
package uart_thre_pkg;
  typedef enum logic [1:0] {
    DLY_IDLE  = 2'd0,
    DLY_WCHAR = 2'd1,
    DLY_WSTOP = 2'd2
  } dly_state_e;
endpackage

// File: rtl/uart_thre_edges.sv
// Registers the control bits and derives their edges.
module uart_thre_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_en,
  input  logic tx_ie,
  output logic fen_chg,
  output logic ie_rise,
  output logic dly_mode
);
  logic fen_q;
  logic ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen_q <= 1'b0;
      ie_q  <= 1'b0;
    end else begin
      fen_q <= fifo_en;
      ie_q  <= tx_ie;
    end
  end

  assign fen_chg  = fifo_en ^ fen_q;
  assign ie_rise  = tx_ie & ~ie_q;
  assign dly_mode = fifo_en & tx_ie;
endmodule

// File: rtl/uart_thre_pair.sv
// Sticky record: occupancy reached PAIR_LEVEL since the last empty report.
module uart_thre_pair #(
  parameter int CNT_W      = 5,
  parameter int PAIR_LEVEL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_level,
  input  logic             thre_rise,
  output logic             pair_seen
);
  localparam logic [CNT_W-1:0] PairLvl = CNT_W'(PAIR_LEVEL);

  logic pair_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pair_q <= 1'b0;
    else if (thre_rise) pair_q <= 1'b0;
    else                pair_q <= pair_q | (fifo_level >= PairLvl);
  end

  assign pair_seen = pair_q;
endmodule

// File: rtl/uart_thre_delay.sv
// Empty status with the optional one-character-minus-stop-bit delay.
module uart_thre_delay
  import uart_thre_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_level,
  input  logic             dly_mode,
  input  logic             fen_chg,
  input  logic             pair_seen,
  input  logic             char_tick,
  input  logic             stop_tick,
  output logic             thre,
  output logic             thre_nxt,
  output logic             thre_rise
);
  dly_state_e dly_q, dly_d;
  logic       was_nz_q;
  logic       thre_q;
  logic       empty_now;
  logic       start_dly;

  assign empty_now = (fifo_level == '0);
  assign start_dly = empty_now & was_nz_q & dly_mode & ~pair_seen & ~fen_chg;

  always_comb begin
    dly_d = dly_q;
    if (!empty_now || fen_chg || !dly_mode) begin
      dly_d = DLY_IDLE;
    end else if (start_dly) begin
      dly_d = DLY_WCHAR;
    end else begin
      case (dly_q)
        DLY_WCHAR: if (char_tick) dly_d = DLY_WSTOP;
        DLY_WSTOP: if (stop_tick) dly_d = DLY_IDLE;
        default:   dly_d = DLY_IDLE;
      endcase
    end
  end

  assign thre_nxt  = empty_now & (dly_d == DLY_IDLE);
  assign thre_rise = thre_nxt & ~thre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q    <= DLY_IDLE;
      was_nz_q <= 1'b0;
      thre_q   <= 1'b1;
    end else begin
      dly_q    <= dly_d;
      was_nz_q <= ~empty_now;
      thre_q   <= thre_nxt;
    end
  end

  assign thre = thre_q;
endmodule

// File: rtl/uart_thre_irq.sv
// Pending transmit-empty request: set on events, cleared by the host.
module uart_thre_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic thre_nxt,
  input  logic thre_rise,
  input  logic fen_chg,
  input  logic ie_rise,
  input  logic tx_ie,
  input  logic thr_wr,
  input  logic iir_rd,
  input  logic thre_top,
  output logic thre_irq
);
  logic pend_q;
  logic set_ev;
  logic clr_ev;

  assign set_ev = tx_ie & thre_nxt & (thre_rise | fen_chg | ie_rise);
  assign clr_ev = thr_wr | (iir_rd & thre_top) | ~tx_ie | ~thre_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (clr_ev) pend_q <= 1'b0;
    else             pend_q <= pend_q | set_ev;
  end

  assign thre_irq = pend_q;
endmodule

// File: rtl/uart_thre_irq_gen.sv
module uart_thre_irq_gen #(
  parameter int FIFO_DEPTH = 16,
  parameter int PAIR_LEVEL = 2,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_level,
  input  logic             thr_wr,
  input  logic             iir_rd,
  input  logic             thre_top,
  input  logic             char_tick,
  input  logic             stop_tick,
  input  logic             fifo_en,
  input  logic             tx_ie,
  output logic             thre,
  output logic             thre_irq
);
  logic fen_chg, ie_rise, dly_mode;
  logic pair_seen, thre_nxt, thre_rise;

  uart_thre_edges u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (fifo_en),
    .tx_ie    (tx_ie),
    .fen_chg  (fen_chg),
    .ie_rise  (ie_rise),
    .dly_mode (dly_mode)
  );

  uart_thre_pair #(.CNT_W(CNT_W), .PAIR_LEVEL(PAIR_LEVEL)) u_pair (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_level (fifo_level),
    .thre_rise  (thre_rise),
    .pair_seen  (pair_seen)
  );

  uart_thre_delay #(.CNT_W(CNT_W)) u_delay (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_level (fifo_level),
    .dly_mode   (dly_mode),
    .fen_chg    (fen_chg),
    .pair_seen  (pair_seen),
    .char_tick  (char_tick),
    .stop_tick  (stop_tick),
    .thre       (thre),
    .thre_nxt   (thre_nxt),
    .thre_rise  (thre_rise)
  );

  uart_thre_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .thre_nxt  (thre_nxt),
    .thre_rise (thre_rise),
    .fen_chg   (fen_chg),
    .ie_rise   (ie_rise),
    .tx_ie     (tx_ie),
    .thr_wr    (thr_wr),
    .iir_rd    (iir_rd),
    .thre_top  (thre_top),
    .thre_irq  (thre_irq)
  );
endmodule

// File: rtl/uart_thre_irq_gen_chk.sv
module uart_thre_irq_gen_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] fifo_level,
  input logic             thr_wr,
  input logic             fifo_en,
  input logic             tx_ie,
  input logic             thre,
  input logic             thre_irq
);
  p_busy_not_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level != '0) |=> !thre);

  p_fast_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((!fifo_en || !tx_ie) && fifo_level == '0) |=> thre);

  p_irq_implies_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    thre_irq |-> thre);

  p_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !thre_irq);

  p_ie_off_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ie |=> !thre_irq);
endmodule

bind uart_thre_irq_gen uart_thre_irq_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_level (fifo_level),
  .thr_wr     (thr_wr),
  .fifo_en    (fifo_en),
  .tx_ie      (tx_ie),
  .thre       (thre),
  .thre_irq   (thre_irq)
);

// File: tb/uart_thre_irq_gen_bench.sv
module uart_thre_irq_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] fifo_level = '0;
  logic       thr_wr = 1'b0, iir_rd = 1'b0, thre_top = 1'b0;
  logic       char_tick = 1'b0, stop_tick = 1'b0;
  logic       fifo_en = 1'b0, tx_ie = 1'b0;
  logic       thre, thre_irq;
  int         n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_thre_irq_gen u_uart_thre_irq_gen (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .thr_wr(thr_wr),
    .iir_rd(iir_rd), .thre_top(thre_top), .char_tick(char_tick),
    .stop_tick(stop_tick), .fifo_en(fifo_en), .tx_ie(tx_ie),
    .thre(thre), .thre_irq(thre_irq)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One fill/drain episode; delayed release expected only in FIFO mode
  // with interrupts enabled and a peak below two entries.
  task automatic episode(input int peak, input bit fen, input bit ie,
                         input int cg, input int sg, input string tag);
    bit slow;
    fifo_en = fen; tx_ie = ie; step();
    thr_wr = 1'b1; step(); thr_wr = 1'b0;
    for (int v = 1; v <= peak; v++) begin
      fifo_level = 5'(v); step(); chk("R2", thre, 1'b0);
    end
    for (int v = peak - 1; v >= 1; v--) begin
      fifo_level = 5'(v); step(); chk("R2", thre, 1'b0);
    end
    fifo_level = '0; step();
    slow = fen && ie && (peak < 2);
    if (!slow) begin
      chk((fen && ie) ? "R5" : "R3", thre, 1'b1);
      chk("R7", thre_irq, ie);
    end else begin
      chk(tag, thre, 1'b0);
      for (int i = 0; i < cg; i++) begin
        stop_tick = 1'b1; step(); chk(tag, thre, 1'b0);
      end
      stop_tick = 1'b0; char_tick = 1'b1; step(); char_tick = 1'b0;
      chk(tag, thre, 1'b0);
      for (int i = 1; i < sg; i++) begin
        step(); chk(tag, thre, 1'b0);
      end
      stop_tick = 1'b1; step(); stop_tick = 1'b0;
      chk(tag, thre, 1'b1);
      chk("R7", thre_irq, 1'b1);
    end
    thr_wr = 1'b1; step(); thr_wr = 1'b0;
    chk("R8", thre_irq, 1'b0);
    chk("R8", thre, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1", thre, 1'b1); chk("R1", thre_irq, 1'b0);
    rst_n = 1'b1; step();
    chk("R1", thre, 1'b1); chk("R1", thre_irq, 1'b0);

    for (int m = 0; m < 3; m++)
      for (int pk = 1; pk <= 3; pk++)
        for (int cg = 1; cg <= 2; cg++)
          for (int sg = 1; sg <= 2; sg++)
            episode(pk, (m != 0), (m != 2), cg, sg, "R4");

    // R6: pair record from a two-entry episode is cleared by the rise
    episode(3, 1'b1, 1'b1, 1, 1, "R5");
    episode(1, 1'b1, 1'b1, 2, 2, "R6");

    // R12: refill during a running delay
    fifo_level = 5'd1; step();
    fifo_level = '0; step(); chk("R12", thre, 1'b0);
    char_tick = 1'b1; step(); char_tick = 1'b0;
    fifo_level = 5'd1; step(); chk("R12", thre, 1'b0);
    fifo_level = '0; step(); chk("R12", thre, 1'b0);
    stop_tick = 1'b1; step(); stop_tick = 1'b0; chk("R12", thre, 1'b0);
    char_tick = 1'b1; step(); char_tick = 1'b0; chk("R12", thre, 1'b0);
    stop_tick = 1'b1; step(); stop_tick = 1'b0; chk("R12", thre, 1'b1);
    thr_wr = 1'b1; step(); thr_wr = 1'b0;

    // R10: FIFO enable change cancels delay and raises request
    fifo_level = 5'd1; step();
    fifo_level = '0; step(); chk("R10", thre, 1'b0);
    fifo_en = 1'b0; step();
    chk("R10", thre, 1'b1); chk("R10", thre_irq, 1'b1);
    thr_wr = 1'b1; step(); thr_wr = 1'b0; chk("R8", thre_irq, 1'b0);
    fifo_en = 1'b1; step(); chk("R10", thre_irq, 1'b1);

    // R9: identification read clears only when this source is on top
    iir_rd = 1'b1; thre_top = 1'b0; step(); chk("R9", thre_irq, 1'b1);
    thre_top = 1'b1; step(); chk("R9", thre_irq, 1'b0);
    iir_rd = 1'b0; thre_top = 1'b0; step(); chk("R9", thre_irq, 1'b0);

    // R11: enable gating and re-raise on enable rise
    fifo_en = 1'b0; step(); chk("R11", thre_irq, 1'b1);
    tx_ie = 1'b0; step(); chk("R11", thre_irq, 1'b0);
    tx_ie = 1'b1; step(); chk("R11", thre_irq, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule